// File: doc/BRIEF.md
# Tiled Frame Fetch Address Generator

This block turns one frame-control word into the full list of memory reads that a scan-out engine needs to move a frame into a linear framebuffer. The frame sits in memory as a set of 64 KB tiles. A table of 16-bit tile handles points to them, and the block walks that table in memory. For each handle it first issues a table read. It then emits burst read requests, each carrying a source address, a byte length and the destination offset in the framebuffer where the data belongs.

Two layouts are supported:

- **Tiled layout.** Each tile is 128 lines of 512 bytes. The tiles cover the screen left to right, then top to bottom. Partial tiles at the right and bottom edges are clipped to the screen.
- **Linear layout.** Each tile is streamed as one contiguous block, split into fixed-size chunks, until the whole frame has been covered.

A start pulse captures the configuration and runs one scan. A one-cycle done pulse marks the end of the scan. All requests leave through one valid/ready port. Table entries come back on a response port, which the block always accepts while it is waiting for an entry.

Top module: `tile_fetch_agen`

## Requirements
- R1: While reset is asserted and right after it, `req_valid` and `done` are low.
- R2: If `frm_ctrl` bit 0 (fetch enable) is 0 when a start is accepted, no request is issued and `done` pulses in the next cycle.
- R3: The table pointer is `frm_ctrl` with bits 8..0 forced to zero. If that pointer is zero, or if the screen width or height is zero, a start issues no request and pulses `done` in the next cycle.
- R4: Table reads use `req_table`=1 and `req_len`=2. The address of table read number k is pointer + 2k, with k counting up from 0. The next table read is issued only after every data request for the current tile has been accepted.
- R5: `rsp_entry[15:8]` is the byte at the lower address. The tile base address is the entry shifted left by 16.
- R6: In tiled mode (`frm_ctrl` bit 1 = 0), line L of a tile is read at tile base + 512×L. A tile has 128 lines, or fewer when only part of the screen height remains.
- R7: The colour depth is 8<<`depth_sel` bits. A tile line holds 512>>`depth_sel` pixels, clipped to the screen width that remains. `req_len` is the clipped pixel count times 2^`depth_sel`.
- R8: In tiled mode, `req_dst` for line L of the tile at position (tx, ty) is ((ty+L)×width + tx) × 2^`depth_sel`.
- R9: In tiled mode, tiles advance in x by one tile width. When the next x would reach the width, x returns to 0 and y advances by 128. The scan ends when y would reach the height, so the number of requests matches this raster order exactly.
- R10: In linear mode (`frm_ctrl` bit 1 = 1), each tile is read in chunks of CHUNK_BYTES at tile base + offset, with offset running from 0 up to 64 KB. `req_dst` counts up from 0 in steps of CHUNK_BYTES. The last chunk is shortened so that the bytes sum to width×height×2^`depth_sel`, and then the scan stops.
- R11: `done` is high for exactly one cycle, in the cycle after the last request is accepted. A start that arrives during a scan is ignored. The configuration is captured when a start is accepted.
- R12: While `req_valid` is high and `req_ready` is low, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start one frame scan (idle only) |
| frm_ctrl | input | ADDR_W | Table pointer in bits 31..9, linear mode in bit 1, fetch enable in bit 0 |
| depth_sel | input | 2 | Colour depth select; depth is 8<<depth_sel bits |
| scr_w | input | DIM_W | Screen width in pixels |
| scr_h | input | DIM_W | Screen height in lines |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high together with req_valid |
| req_table | output | 1 | 1 for a table entry read, 0 for a pixel burst |
| req_addr | output | ADDR_W | Source byte address |
| req_len | output | LEN_W | Burst length in bytes |
| req_dst | output | ADDR_W | Destination framebuffer byte offset (pixel bursts) |
| rsp_valid | input | 1 | Table entry present |
| rsp_entry | input | 16 | Table entry; bits 15..8 come from the lower address |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The assertions check, on every cycle, that a stalled request holds its fields, that `done` never lasts more than one cycle and never coincides with a request, that table reads are two bytes long, and that pixel bursts are non-empty, 512-byte aligned and within the chunk bound. Only the bench scenarios can show the rest: the exact raster order, the edge clipping, the destination offsets, the linear chunk split across tile boundaries with a shortened last chunk, and the handling of an ignored mid-scan start. To do this, the bench compares the complete request list against a model built from the requirements for each depth and layout.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
    localparam int TILE_LINE_BYTES = 512;
    localparam int TILE_LINE_LOG2  = 9;
    localparam int TILE_LINES      = 128;
    localparam int TILE_SHIFT      = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TREQ,
        ST_TWAIT,
        ST_LINE,
        ST_LIN,
        ST_DONE
    } tfa_state_e;
endpackage

// File: rtl/tfa_geom.sv
module tfa_geom #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 12,
    parameter int LEN_W  = 15,
    parameter int LINE_W = 8
) (
    input  logic [1:0]        sel,
    input  logic [DIM_W-1:0]  w,
    input  logic [DIM_W-1:0]  h,
    input  logic [DIM_W-1:0]  tx,
    input  logic [DIM_W-1:0]  ty,
    input  logic [LINE_W-1:0] ln,
    output logic [DIM_W:0]    tpx,
    output logic [LINE_W-1:0] nlines,
    output logic [LEN_W-1:0]  lbytes,
    output logic [ADDR_W-1:0] dst,
    output logic              row_end,
    output logic              frame_end
);
    import tfa_pkg::*;

    logic [DIM_W:0]   rem_x, rem_y, px;
    logic [DIM_W+3:0] pxb;
    logic [ADDR_W-1:0] row;

    always_comb begin
        tpx       = (DIM_W+1)'(TILE_LINE_BYTES) >> sel;
        rem_x     = {1'b0, w} - {1'b0, tx};
        px        = (rem_x < tpx) ? rem_x : tpx;
        pxb       = {3'b000, px} << sel;
        lbytes    = LEN_W'(pxb);
        rem_y     = {1'b0, h} - {1'b0, ty};
        nlines    = (rem_y < (DIM_W+1)'(TILE_LINES)) ? LINE_W'(rem_y) : LINE_W'(TILE_LINES);
        row       = ADDR_W'(ty) + ADDR_W'(ln);
        dst       = ((row * ADDR_W'(w)) + ADDR_W'(tx)) << sel;
        row_end   = ({1'b0, tx} + tpx) >= {1'b0, w};
        frame_end = ({1'b0, ty} + (DIM_W+1)'(TILE_LINES)) >= {1'b0, h};
    end
endmodule

// File: rtl/tfa_chunk.sv
module tfa_chunk #(
    parameter int ADDR_W      = 32,
    parameter int DIM_W       = 12,
    parameter int LEN_W       = 15,
    parameter int CHUNK_BYTES = 16384
) (
    input  logic [1:0]        sel,
    input  logic [DIM_W-1:0]  w,
    input  logic [DIM_W-1:0]  h,
    input  logic [ADDR_W-1:0] fbo,
    output logic [LEN_W-1:0]  clen,
    output logic              last
);
    logic [ADDR_W-1:0] total, rem;

    always_comb begin
        total = (ADDR_W'(w) * ADDR_W'(h)) << sel;
        rem   = total - fbo;
        last  = rem <= ADDR_W'(CHUNK_BYTES);
        clen  = last ? LEN_W'(rem) : LEN_W'(CHUNK_BYTES);
    end
endmodule

// File: rtl/tile_fetch_agen.sv
module tile_fetch_agen #(
    parameter int ADDR_W      = 32,
    parameter int DIM_W       = 12,
    parameter int IDX_W       = 16,
    parameter int CHUNK_BYTES = 16384,   // power of two, 512 .. 65536
    localparam int LEN_W      = $clog2(CHUNK_BYTES) + 1,
    localparam int LINE_W     = $clog2(tfa_pkg::TILE_LINES) + 1,
    localparam int CO_W       = tfa_pkg::TILE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] frm_ctrl,
    input  logic [1:0]        depth_sel,
    input  logic [DIM_W-1:0]  scr_w,
    input  logic [DIM_W-1:0]  scr_h,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_table,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [ADDR_W-1:0] req_dst,
    input  logic              rsp_valid,
    input  logic [15:0]       rsp_entry,
    output logic              done
);
    import tfa_pkg::*;

    typedef struct packed {
        tfa_state_e        st;
        logic [ADDR_W-1:0] tptr;
        logic              lin;
        logic [1:0]        sel;
        logic [DIM_W-1:0]  w;
        logic [DIM_W-1:0]  h;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] tbase;
        logic [DIM_W-1:0]  tx;
        logic [DIM_W-1:0]  ty;
        logic [LINE_W-1:0] ln;
        logic [CO_W-1:0]   co;
        logic [ADDR_W-1:0] fbo;
    } scan_t;

    scan_t s_d, s_q;

    logic [DIM_W:0]    g_tpx;
    logic [LINE_W-1:0] g_nl;
    logic [LEN_W-1:0]  g_len, c_len;
    logic [ADDR_W-1:0] g_dst;
    logic              g_row_end, g_frame_end, c_last;
    logic [CO_W-1:0]   co_nx;
    logic [ADDR_W-1:0] ptr_in;

    tfa_geom #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .LEN_W(LEN_W), .LINE_W(LINE_W)) u_geom (
        .sel(s_q.sel), .w(s_q.w), .h(s_q.h), .tx(s_q.tx), .ty(s_q.ty), .ln(s_q.ln),
        .tpx(g_tpx), .nlines(g_nl), .lbytes(g_len), .dst(g_dst),
        .row_end(g_row_end), .frame_end(g_frame_end)
    );

    tfa_chunk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) u_chunk (
        .sel(s_q.sel), .w(s_q.w), .h(s_q.h), .fbo(s_q.fbo),
        .clen(c_len), .last(c_last)
    );

    assign ptr_in = {frm_ctrl[ADDR_W-1:TILE_LINE_LOG2], TILE_LINE_LOG2'(0)};
    assign co_nx  = s_q.co + CO_W'(CHUNK_BYTES);

    always_comb begin
        s_d       = s_q;
        req_valid = 1'b0;
        req_table = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        req_dst   = '0;
        done      = (s_q.st == ST_DONE);
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.tptr = ptr_in;
                    s_d.lin  = frm_ctrl[1];
                    s_d.sel  = depth_sel;
                    s_d.w    = scr_w;
                    s_d.h    = scr_h;
                    s_d.idx  = '0;
                    s_d.tx   = '0;
                    s_d.ty   = '0;
                    s_d.fbo  = '0;
                    if (!frm_ctrl[0] || ptr_in == '0 || scr_w == '0 || scr_h == '0)
                        s_d.st = ST_DONE;
                    else
                        s_d.st = ST_TREQ;
                end
            end
            ST_TREQ: begin
                req_valid = 1'b1;
                req_table = 1'b1;
                req_addr  = s_q.tptr + (ADDR_W'(s_q.idx) << 1);
                req_len   = LEN_W'(2);
                if (req_ready) s_d.st = ST_TWAIT;
            end
            ST_TWAIT: begin
                if (rsp_valid) begin
                    s_d.tbase = ADDR_W'(rsp_entry) << TILE_SHIFT;
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.ln    = '0;
                    s_d.co    = '0;
                    s_d.st    = s_q.lin ? ST_LIN : ST_LINE;
                end
            end
            ST_LINE: begin
                req_valid = 1'b1;
                req_addr  = s_q.tbase + (ADDR_W'(s_q.ln) << TILE_LINE_LOG2);
                req_len   = g_len;
                req_dst   = g_dst;
                if (req_ready) begin
                    if (LINE_W'(s_q.ln + 1'b1) == g_nl) begin
                        if (g_row_end) begin
                            s_d.tx = '0;
                            s_d.ty = s_q.ty + DIM_W'(TILE_LINES);
                            s_d.st = g_frame_end ? ST_DONE : ST_TREQ;
                        end else begin
                            s_d.tx = s_q.tx + DIM_W'(g_tpx);
                            s_d.st = ST_TREQ;
                        end
                    end else begin
                        s_d.ln = s_q.ln + 1'b1;
                    end
                end
            end
            ST_LIN: begin
                req_valid = 1'b1;
                req_addr  = s_q.tbase + ADDR_W'(s_q.co);
                req_len   = c_len;
                req_dst   = s_q.fbo;
                if (req_ready) begin
                    s_d.fbo = s_q.fbo + ADDR_W'(CHUNK_BYTES);
                    s_d.co  = co_nx;
                    if (c_last)                 s_d.st = ST_DONE;
                    else if (co_nx[TILE_SHIFT]) s_d.st = ST_TREQ;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)
                                     && $stable(req_dst) && $stable(req_table));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
    // R4
    table_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_table |-> req_len == LEN_W'(2));
    // R6
    burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_table |-> req_addr[TILE_LINE_LOG2-1:0] == '0);
    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_table |-> req_len != '0 && req_len <= LEN_W'(CHUNK_BYTES));
endmodule

// File: tb/test_tile_fetch_agen.sv
module test_tile_fetch_agen;
    localparam int PER   = 10;
    localparam int CHUNK = 16384;
    localparam int LEN_W = $clog2(CHUNK) + 1;
    localparam int MAXR  = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       frm_ctrl = '0;
    logic [1:0]        depth_sel = '0;
    logic [11:0]       scr_w = '0, scr_h = '0;
    logic              req_valid, req_table;
    logic              req_ready = 1'b0;
    logic [31:0]       req_addr, req_dst;
    logic [LEN_W-1:0]  req_len;
    logic              rsp_valid = 1'b0;
    logic [15:0]       rsp_entry = '0;
    logic              done;

    tile_fetch_agen #(.CHUNK_BYTES(CHUNK)) i_tile_fetch_agen (
        .clk(clk), .rst_n(rst_n), .start(start), .frm_ctrl(frm_ctrl),
        .depth_sel(depth_sel), .scr_w(scr_w), .scr_h(scr_h),
        .req_valid(req_valid), .req_ready(req_ready), .req_table(req_table),
        .req_addr(req_addr), .req_len(req_len), .req_dst(req_dst),
        .rsp_valid(rsp_valid), .rsp_entry(rsp_entry), .done(done)
    );

    always #(PER/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    logic [31:0] got_addr [MAXR], got_len [MAXR], got_dst [MAXR];
    logic        got_tbl  [MAXR];
    logic [31:0] exp_addr [MAXR], exp_len [MAXR], exp_dst [MAXR];
    logic        exp_tbl  [MAXR];
    int got_n = 0, exp_n = 0, done_cnt = 0, done_cyc = 0, last_cyc = 0;
    logic [31:0] cur_ptr = '0;
    logic        rsp_pend = 1'b0;
    int          rsp_idx = 0;
    logic        stalled = 1'b0;
    logic [31:0] st_addr = '0;

    function automatic logic [15:0] ent(int i);
        return 16'h0100 + 16'(i * 3);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver and monitor, away from the rising edge
    always begin
        @(negedge clk);
        rsp_valid = rsp_pend;
        rsp_entry = ent(rsp_idx);
        rsp_pend  = 1'b0;
        req_ready = (cyc % 5) != 3;
        #1;
        if (rst_n && stalled) begin
            // R12 stalled request must hold
            chk("R12", "held request", {31'b0, req_valid} * 64'h1_0000_0000 + req_addr,
                64'h1_0000_0000 + st_addr);
        end
        stalled = rst_n && req_valid && !req_ready;
        st_addr = req_addr;
        if (rst_n && req_valid && req_ready) begin
            if (got_n < MAXR) begin
                got_addr[got_n] = req_addr;
                got_len[got_n]  = 32'(req_len);
                got_dst[got_n]  = req_dst;
                got_tbl[got_n]  = req_table;
            end
            got_n++;
            last_cyc = cyc;
            if (req_table) begin
                rsp_pend = 1'b1;
                rsp_idx  = int'((req_addr - cur_ptr) >> 1);
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            done_cyc = cyc;
        end
    end

    task automatic push(logic t, logic [31:0] a, logic [31:0] l, logic [31:0] d);
        if (exp_n < MAXR) begin
            exp_tbl[exp_n] = t; exp_addr[exp_n] = a; exp_len[exp_n] = l; exp_dst[exp_n] = d;
        end
        exp_n++;
    endtask

    task automatic build(logic [31:0] ctrl, int sel, int w, int h);
        logic [31:0] ptr, tb;
        int idx, tpx, nl, px, total, fbo;
        exp_n = 0;
        ptr = ctrl & 32'hFFFF_FE00;
        if (!ctrl[0] || ptr == 0 || w == 0 || h == 0) return;
        idx = 0;
        if (!ctrl[1]) begin
            tpx = 512 >> sel;
            for (int ty = 0; ty < h; ty += 128) begin
                for (int tx = 0; tx < w; tx += tpx) begin
                    push(1'b1, ptr + 32'(2 * idx), 2, 0);
                    tb = {ent(idx), 16'h0000};
                    idx++;
                    nl = (h - ty < 128) ? h - ty : 128;
                    px = (w - tx < tpx) ? w - tx : tpx;
                    for (int l = 0; l < nl; l++)
                        push(1'b0, tb + 32'(512 * l), 32'(px << sel),
                             32'(((ty + l) * w + tx) << sel));
                end
            end
        end else begin
            total = (w * h) << sel;
            fbo = 0;
            while (fbo < total) begin
                push(1'b1, ptr + 32'(2 * idx), 2, 0);
                tb = {ent(idx), 16'h0000};
                idx++;
                for (int co = 0; co < 65536 && fbo < total; co += CHUNK) begin
                    push(1'b0, tb + 32'(co), 32'((total - fbo < CHUNK) ? total - fbo : CHUNK),
                         32'(fbo));
                    fbo += CHUNK;
                end
            end
        end
    endtask

    task automatic run_scan(logic [31:0] ctrl, int sel, int w, int h, bit again);
        int t;
        string ra, rl, rd;
        build(ctrl, sel, w, h);
        @(negedge clk);
        got_n = 0; done_cnt = 0;
        cur_ptr = ctrl & 32'hFFFF_FE00;
        frm_ctrl = ctrl; depth_sel = 2'(sel); scr_w = 12'(w); scr_h = 12'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (again) begin
            repeat (20) @(negedge clk);
            // R11 second start mid-scan with a different configuration
            frm_ctrl = 32'h0009_0003; depth_sel = 2'd0; scr_w = 12'd16; scr_h = 12'd4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 50000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
        chk("R11", "done pulses", done_cnt, 1);
        chk("R9", "request count", got_n, exp_n);
        if (exp_n > 0 && got_n > 0)
            chk("R11", "done cycle", done_cyc, last_cyc + 1);
        ra = ctrl[1] ? "R10" : "R5,R6";
        rl = ctrl[1] ? "R10" : "R7";
        rd = ctrl[1] ? "R10" : "R8";
        for (int i = 0; i < exp_n && i < got_n && i < MAXR; i++) begin
            chk("R4", "kind", got_tbl[i], exp_tbl[i]);
            chk(exp_tbl[i] ? "R4" : ra, "addr", got_addr[i], exp_addr[i]);
            chk(exp_tbl[i] ? "R4" : rl, "len", got_len[i], exp_len[i]);
            if (!exp_tbl[i]) chk(rd, "dst", got_dst[i], exp_dst[i]);
        end
    endtask

    typedef struct packed {
        logic [31:0] ctrl;
        logic [3:0]  sel;
        logic [11:0] w;
        logic [11:0] h;
    } scn_t;

    localparam scn_t SCN [6] = '{
        '{32'h0004_11FD, 4'd0, 12'd1000, 12'd300},  // tiled, masked low bits
        '{32'h0002_0001, 4'd1, 12'd300,  12'd130},  // tiled 16 bpp, bottom clip
        '{32'h0002_0201, 4'd2, 12'd200,  12'd100},  // tiled 32 bpp
        '{32'h0003_03FF, 4'd0, 12'd300,  12'd256},  // linear, crosses tile, short tail
        '{32'h0003_0003, 4'd1, 12'd64,   12'd8},    // linear, single short chunk
        '{32'h0000_0E01, 4'd3, 12'd64,   12'd128}   // tiled, exact single tile
    };

    initial begin
        #(PER * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "req_valid in reset", req_valid, 0);
        chk("R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk("R1", "req_valid after reset", req_valid, 0);
        chk("R1", "done after reset", done, 0);

        for (int k = 0; k < 6; k++)
            run_scan(SCN[k].ctrl, int'(SCN[k].sel), int'(SCN[k].w), int'(SCN[k].h), 1'b0);

        // R2 fetch enable clear: no requests
        run_scan(32'h0004_1002, 0, 640, 480, 1'b0);
        chk("R2", "no requests when disabled", got_n, 0);
        // R3 zero table pointer, low bits ignored
        run_scan(32'h0000_01FF, 0, 640, 480, 1'b0);
        chk("R3", "no requests for zero pointer", got_n, 0);
        // R3 zero width
        run_scan(32'h0004_1001, 0, 0, 480, 1'b0);
        chk("R3", "no requests for zero width", got_n, 0);
        // R11 start while busy is ignored
        run_scan(SCN[1].ctrl, int'(SCN[1].sel), int'(SCN[1].w), int'(SCN[1].h), 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule